// File: doc/BRIEF.md
# Static Memory Bank Controller

This block sits between a simple single-request internal bus and an external asynchronous static memory bus with four chip-select regions. The top two bits of the request address pick the region. The low 24 bits are driven on the external address pins. The region's chip select, output enable, write enable and byte-lane strobes are then driven with the timing that the region's configuration gives.

Each region has its own configuration word. The word holds the read wait states, the write wait states, a reduced wait count for sequential reads, the bus-turnaround idle count, a sequential-read enable, a write-protect flag and the data width (8, 16 or 32 bits). Only one request is in flight at a time. The requester sees a one-cycle response that carries the read data, or an error flag when a write targets a protected region.

The configuration arrives as a flat input vector. Region n occupies bits [20n+19:20n]: rd wait [3:0], wr wait [7:4], seq wait [11:8], turnaround [15:12], seq enable [16], protect [17], width [19:18] (0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit).

Top module: `smc_bank_ctrl`

## Requirements
- R1: After reset all chip selects, output enable, write enable and byte-lane strobes are high (inactive), the data drive enable is low, req_ready is 1 and rsp_valid is 0.
- R2: req_addr[25:24] selects the region; during an access only that region's mem_cs_n bit is low, and mem_addr equals req_addr[23:0].
- R3: A read holds mem_oe_n low for rd_wait+1 cycles. The cycle after the last of these, rsp_valid is 1 for one cycle with rsp_err 0 and the aligned read data.
- R4: A write holds mem_we_n low and mem_doe high for wr_wait+1 cycles, with mem_bls_n low on the written lanes; a response cycle follows.
- R5: A write to a protected region drives no strobe. The cycle after acceptance, rsp_valid and rsp_err are both 1, and the last-access history is left unchanged.
- R6: When the region changes from the previous external access, turnaround idle cycles (the previous region's count) pass before the strobes, with every strobe inactive.
- R7: A write that follows a read in the same region is also preceded by the previous region's turnaround count.
- R8: Write-after-write, write-after-read in the other direction (read after write) and read-after-read in the same region insert no turnaround cycles.
- R9: With the sequential-read enable set, a read that directly follows a read in the same region, at the previous address plus the width in bytes (1, 2 or 4) and inside the same 16-byte page, uses seq_wait instead of rd_wait.
- R10: A read that skips an address or crosses a 16-byte page uses rd_wait.
- R11: In a 16-bit region, req_addr[1] picks the halfword. Writes put that halfword on mem_dout[15:0] with strobes {2'b00, be pair}, and reads return mem_din[15:0] in the chosen halfword of rsp_rdata with zeros elsewhere.
- R12: In an 8-bit region, req_addr[1:0] picks the byte. Writes drive mem_dout[7:0] and strobe only lane 0, and only when that byte's enable is set; reads return mem_din[7:0] in the chosen byte lane.
- R13: req_ready is 0 from the edge that accepts a request until the response cycle has ended. A request held high during that time is not accepted again, and rsp_valid never lasts two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i | input | 80 | Per-region configuration, 20 bits per region |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Region in [25:24], byte address in [23:0] |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | One-cycle response |
| rsp_err | output | 1 | Protected-write error |
| rsp_rdata | output | 32 | Read data, lane aligned |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_bls_n | output | 4 | Active-low byte-lane strobes (writes) |
| mem_addr | output | 24 | External address |
| mem_dout | output | 32 | External write data |
| mem_doe | output | 1 | Drive enable for mem_dout |
| mem_din | input | 32 | External read data |

## Verification
The bench goes after the turnaround decision on each kind of transition. A design that keyed turnaround on the new region's count, or added it on read-after-write, would shift every later strobe by one or more cycles. Sequential reads are tried at the exact next address, one word past it and across a page edge. A design that got the page test or the width-based step wrong would use the short wait on the wrong read. A protected write is held on the bus through its response. A design that still strobed, updated the access history or re-accepted the held request would show a stray mem_we_n, a missing turnaround on the next access or a second response. The narrow regions are exercised on odd lanes, where a mis-steered byte or halfword shows up on mem_dout, mem_bls_n or rsp_rdata.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int WAIT_W = 4;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef struct packed {
    logic [1:0]        width;
    logic              wp;
    logic              burst;
    logic [WAIT_W-1:0] turn;
    logic [WAIT_W-1:0] seqw;
    logic [WAIT_W-1:0] wrw;
    logic [WAIT_W-1:0] rdw;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_ACC, S_RESP} smc_state_t;

  function automatic logic [2:0] width_step(input logic [1:0] width);
    case (width)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] align_read(input logic [1:0] width,
                                                   input logic [1:0] lane,
                                                   input logic [DATA_W-1:0] din);
    case (width)
      2'd0:    return {24'h0, din[7:0]} << {lane, 3'b000};
      2'd1:    return {16'h0, din[15:0]} << {lane[1], 4'b0000};
      default: return din;
    endcase
  endfunction
endpackage

// File: rtl/smc_cfg_mux.sv
module smc_cfg_mux
  import smc_pkg::*;
#(
  parameter int SEL_W = 2,
  localparam int NBANK = 1 << SEL_W
) (
  input  logic [NBANK*CFG_W-1:0] cfg_flat,
  input  logic [SEL_W-1:0]       sel,
  output bank_cfg_t              cfg
);
  bank_cfg_t arr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_unpack
    assign arr[g] = cfg_flat[g*CFG_W +: CFG_W];
  end

  assign cfg = arr[sel];
endmodule

// File: rtl/smc_lane_steer.sv
module smc_lane_steer
  import smc_pkg::*;
(
  input  logic [1:0]        width,
  input  logic [1:0]        lane,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  bls,
  output logic [DATA_W-1:0] dout
);
  always_comb begin
    case (width)
      2'd0: begin
        bls  = {3'b000, be[lane]};
        dout = {24'h0, wdata[{lane, 3'b000} +: 8]};
      end
      2'd1: begin
        bls  = {2'b00, be[{lane[1], 1'b0} +: 2]};
        dout = {16'h0, wdata[{lane[1], 4'b0000} +: 16]};
      end
      default: begin
        bls  = be;
        dout = wdata;
      end
    endcase
  end
endmodule

// File: rtl/smc_seq_track.sv
module smc_seq_track
  import smc_pkg::*;
#(
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [SEL_W-1:0]  req_bank,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [1:0]        width,
  input  logic              burst,
  output logic              need_turn,
  output logic              is_seq,
  output logic [SEL_W-1:0]  last_bank
);
  logic              last_v;
  logic              last_rd;
  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] next_addr;

  assign next_addr = last_addr + ADDR_W'(width_step(width));

  always_ff @(posedge clk) begin
    if (rst) begin
      last_v    <= 1'b0;
      last_rd   <= 1'b0;
      last_bank <= '0;
      last_addr <= '0;
    end else if (upd) begin
      last_v    <= 1'b1;
      last_rd   <= !req_we;
      last_bank <= req_bank;
      last_addr <= req_addr;
    end
  end

  assign need_turn = last_v && ((req_bank != last_bank) || (last_rd && req_we));
  assign is_seq    = last_v && last_rd && !req_we && burst && (req_bank == last_bank)
                  && (req_addr == next_addr)
                  && (req_addr[ADDR_W-1:4] == last_addr[ADDR_W-1:4]);
endmodule

// File: rtl/smc_bank_ctrl.sv
module smc_bank_ctrl
  import smc_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int EXT_AW    = 24,
  localparam int NBANK    = 1 << BANK_BITS,
  localparam int REQ_AW   = EXT_AW + BANK_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NBANK*CFG_W-1:0] cfg_i,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [REQ_AW-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [LANES-1:0]       req_be,
  output logic                   rsp_valid,
  output logic                   rsp_err,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [NBANK-1:0]       mem_cs_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  output logic [LANES-1:0]       mem_bls_n,
  output logic [EXT_AW-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_dout,
  output logic                   mem_doe,
  input  logic [DATA_W-1:0]      mem_din
);
  logic [BANK_BITS-1:0] req_bank;
  logic [BANK_BITS-1:0] last_bank;
  bank_cfg_t            sel_cfg;
  bank_cfg_t            prev_cfg;
  logic                 need_turn;
  logic                 is_seq;
  logic [LANES-1:0]     st_bls;
  logic [DATA_W-1:0]    st_dout;

  smc_state_t           state;
  logic [WAIT_W-1:0]    cnt;
  logic [WAIT_W-1:0]    acc_wait;
  logic [WAIT_W-1:0]    wait_now;
  logic [BANK_BITS-1:0] lat_bank;
  logic                 lat_we;
  logic [1:0]           lat_width;
  logic [1:0]           lat_lane;
  logic [LANES-1:0]     lat_bls;

  logic                 accept;
  logic                 prot;
  logic                 from_idle;
  logic [BANK_BITS-1:0] on_bank;
  logic                 on_we;
  logic [LANES-1:0]     on_bls;
  logic [NBANK-1:0]     on_cs_n;

  assign req_bank = req_addr[REQ_AW-1:EXT_AW];

  smc_cfg_mux #(.SEL_W(BANK_BITS)) u_cfg_req (
    .cfg_flat(cfg_i), .sel(req_bank), .cfg(sel_cfg)
  );

  smc_cfg_mux #(.SEL_W(BANK_BITS)) u_cfg_prev (
    .cfg_flat(cfg_i), .sel(last_bank), .cfg(prev_cfg)
  );

  smc_lane_steer u_steer (
    .width(sel_cfg.width), .lane(req_addr[1:0]), .be(req_be),
    .wdata(req_wdata), .bls(st_bls), .dout(st_dout)
  );

  assign accept = (state == S_IDLE) && req_valid;
  assign prot   = req_we && sel_cfg.wp;

  smc_seq_track #(.SEL_W(BANK_BITS), .ADDR_W(EXT_AW)) u_track (
    .clk(clk), .rst(rst), .upd(accept && !prot),
    .req_bank(req_bank), .req_addr(req_addr[EXT_AW-1:0]), .req_we(req_we),
    .width(sel_cfg.width), .burst(sel_cfg.burst),
    .need_turn(need_turn), .is_seq(is_seq), .last_bank(last_bank)
  );

  assign wait_now  = req_we ? sel_cfg.wrw : (is_seq ? sel_cfg.seqw : sel_cfg.rdw);
  assign from_idle = (state == S_IDLE);
  assign on_bank   = from_idle ? req_bank : lat_bank;
  assign on_we     = from_idle ? req_we : lat_we;
  assign on_bls    = from_idle ? st_bls : lat_bls;
  assign on_cs_n   = ~(NBANK'(1) << on_bank);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      mem_cs_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_bls_n <= '1;
      mem_doe   <= 1'b0;
      mem_addr  <= '0;
      mem_dout  <= '0;
      cnt       <= '0;
      acc_wait  <= '0;
      lat_bank  <= '0;
      lat_we    <= 1'b0;
      lat_width <= '0;
      lat_lane  <= '0;
      lat_bls   <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          req_ready <= 1'b0;
          mem_addr  <= req_addr[EXT_AW-1:0];
          mem_dout  <= st_dout;
          lat_bank  <= req_bank;
          lat_we    <= req_we;
          lat_width <= sel_cfg.width;
          lat_lane  <= req_addr[1:0];
          lat_bls   <= st_bls;
          acc_wait  <= wait_now;
          if (prot) begin
            state     <= S_RESP;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
          end else if (need_turn && (prev_cfg.turn != '0)) begin
            state <= S_TURN;
            cnt   <= prev_cfg.turn - 1'b1;
          end else begin
            state     <= S_ACC;
            cnt       <= wait_now;
            mem_cs_n  <= on_cs_n;
            mem_oe_n  <= on_we;
            mem_we_n  <= !on_we;
            mem_bls_n <= on_we ? ~on_bls : '1;
            mem_doe   <= on_we;
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            state     <= S_ACC;
            cnt       <= acc_wait;
            mem_cs_n  <= on_cs_n;
            mem_oe_n  <= on_we;
            mem_we_n  <= !on_we;
            mem_bls_n <= on_we ? ~on_bls : '1;
            mem_doe   <= on_we;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_ACC: begin
          if (cnt == '0) begin
            state     <= S_RESP;
            mem_cs_n  <= '1;
            mem_oe_n  <= 1'b1;
            mem_we_n  <= 1'b1;
            mem_bls_n <= '1;
            mem_doe   <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b0;
            if (!lat_we) rsp_rdata <= align_read(lat_width, lat_lane, mem_din);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          state     <= S_IDLE;
          rsp_valid <= 1'b0;
          rsp_err   <= 1'b0;
          req_ready <= 1'b1;
        end
      endcase
    end
  end

  // R2: at most one region selected at a time
  p_cs_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  // R3: read and write strobes never overlap
  p_oe_we_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  // R5: write enable never reaches a protected region
  p_no_prot_write_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !prev_cfg.wp);

  // R13: response is a single-cycle pulse
  p_rsp_pulse_r13: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R13: no new request taken while the external bus is in use
  p_busy_r13: assert property (@(posedge clk) disable iff (rst)
    (mem_cs_n != '1) |-> !req_ready);

  // R4: data is driven only while write enable is low
  p_doe_we_r4: assert property (@(posedge clk) disable iff (rst)
    mem_doe |-> !mem_we_n);
endmodule

// File: tb/smc_bank_ctrl_tb_top.sv
module smc_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [79:0] cfg_i;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_cs_n;
  logic        mem_oe_n, mem_we_n, mem_doe;
  logic [3:0]  mem_bls_n;
  logic [23:0] mem_addr;
  logic [31:0] mem_dout, mem_din;

  always #(CLK_PERIOD/2) clk = ~clk;

  // per-region settings: read, write, sequential, turnaround, seq enable, protect, width
  int rdw[4]  = '{2, 1, 2, 3};
  int wrw[4]  = '{1, 3, 0, 2};
  int sqw[4]  = '{0, 0, 1, 0};
  int trn[4]  = '{2, 1, 3, 1};
  int bst[4]  = '{1, 0, 1, 0};
  int wpr[4]  = '{0, 0, 0, 1};
  int wid[4]  = '{2, 1, 0, 2};

  initial begin
    for (int b = 0; b < 4; b++)
      cfg_i[b*20 +: 20] = {wid[b][1:0], wpr[b][0], bst[b][0], trn[b][3:0],
                           sqw[b][3:0], wrw[b][3:0], rdw[b][3:0]};
  end

  function automatic logic [31:0] memval(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8], a[7:0] + 8'h3C, a[23:16] ^ a[7:0]};
  endfunction

  assign mem_din = memval(mem_addr);

  smc_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .cfg_i(cfg_i),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_bls_n(mem_bls_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din)
  );

  typedef struct {
    bit          rdy, rv, err, chk_rd, oe_n, we_n, doe;
    logic [3:0]  cs_n, bls_n;
    logic [23:0] addr;
    logic [31:0] dout, rdata;
    string       tag;
  } exp_t;

  exp_t  q[$];
  exp_t  cur;
  string cur_tag = "R1";
  int    acc_cnt = 0;
  int    checks = 0, errors = 0;
  bit    done = 0;
  bit    lv = 0, lr = 0;
  int    lb = 0;
  logic [23:0] la = '0;

  function automatic exp_t idle_e(input string t);
    exp_t e;
    e.rdy = 1; e.rv = 0; e.err = 0; e.chk_rd = 0; e.oe_n = 1; e.we_n = 1; e.doe = 0;
    e.cs_n = 4'hF; e.bls_n = 4'hF; e.addr = '0; e.dout = '0; e.rdata = '0; e.tag = t;
    return e;
  endfunction

  // behavioural reference: builds the cycle schedule of one request
  task automatic schedule(input logic we, input logic [25:0] a, input logic [31:0] wd,
                          input logic [3:0] be);
    int b, k, nturn, nwait, step;
    bit seq;
    exp_t e;
    logic [3:0]  bls;
    logic [31:0] dout, rd;
    b = int'(a[25:24]);
    e = idle_e(cur_tag);
    e.rdy = 0;
    if (we && wpr[b] != 0) begin
      e.rv = 1; e.err = 1;
      q.push_back(e);
      return;
    end
    nturn = (lv && (b != lb || (lr && we))) ? trn[lb] : 0;
    step = (wid[b] == 0) ? 1 : (wid[b] == 1) ? 2 : 4;
    seq = lv && lr && !we && bst[b] != 0 && b == lb &&
          (int'(a[23:0]) == int'(la) + step) && (a[23:4] == la[23:4]);
    nwait = we ? wrw[b] : (seq ? sqw[b] : rdw[b]);
    if (wid[b] == 0) begin
      k = int'(a[1:0]);
      bls = {3'b000, be[k]};
      dout = (wd >> (8*k)) & 32'hFF;
    end else if (wid[b] == 1) begin
      k = int'(a[1]);
      bls = (be >> (2*k)) & 4'b0011;
      dout = (wd >> (16*k)) & 32'hFFFF;
    end else begin
      bls = be; dout = wd;
    end
    rd = memval(a[23:0]);
    if (wid[b] == 0) rd = (rd & 32'hFF) << (8*int'(a[1:0]));
    else if (wid[b] == 1) rd = (rd & 32'hFFFF) << (16*int'(a[1]));
    for (int i = 0; i < nturn; i++) q.push_back(e);
    for (int i = 0; i <= nwait; i++) begin
      exp_t x;
      x = e;
      x.cs_n = ~(4'b0001 << b); x.addr = a[23:0];
      x.oe_n = we; x.we_n = !we; x.doe = we;
      x.bls_n = we ? ~bls : 4'hF; x.dout = dout;
      q.push_back(x);
    end
    e.rv = 1; e.chk_rd = !we; e.rdata = rd;
    q.push_back(e);
    lv = 1; lb = b; lr = !we; la = a[23:0];
  endtask

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = idle_e(cur_tag);
      lv = 0;
    end else begin
      if (cur.rdy && req_valid) begin
        acc_cnt++;
        schedule(req_we, req_addr, req_wdata, req_be);
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_e(cur_tag);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      bit ok;
      ok = (req_ready === cur.rdy) && (rsp_valid === cur.rv) && (mem_cs_n === cur.cs_n)
        && (mem_oe_n === cur.oe_n) && (mem_we_n === cur.we_n)
        && (mem_bls_n === cur.bls_n) && (mem_doe === cur.doe);
      if (cur.cs_n != 4'hF) ok = ok && (mem_addr === cur.addr);
      if (cur.doe) ok = ok && (mem_dout === cur.dout);
      if (cur.rv) ok = ok && (rsp_err === cur.err);
      if (cur.rv && cur.chk_rd) ok = ok && (rsp_rdata === cur.rdata);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s t=%0t act rdy=%b rv=%b err=%b cs=%h oe=%b we=%b bls=%h doe=%b a=%h d=%h rd=%h exp rdy=%b rv=%b err=%b cs=%h oe=%b we=%b bls=%h doe=%b a=%h d=%h rd=%h",
          cur.tag, $time, req_ready, rsp_valid, rsp_err, mem_cs_n, mem_oe_n, mem_we_n,
          mem_bls_n, mem_doe, mem_addr, mem_dout, rsp_rdata,
          cur.rdy, cur.rv, cur.err, cur.cs_n, cur.oe_n, cur.we_n, cur.bls_n, cur.doe,
          cur.addr, cur.dout, cur.rdata);
      end
    end
  end

  task automatic do_req(input string tag, input logic we, input logic [25:0] a,
                        input logic [31:0] wd, input logic [3:0] be, input bit hold);
    int n;
    @(negedge clk);
    cur_tag = tag;
    req_we = we; req_addr = a; req_wdata = wd; req_be = be; req_valid = 1'b1;
    n = acc_cnt;
    while (acc_cnt == n) @(negedge clk);
    if (hold) begin
      while (!(q.size() == 0 && cur.rv)) @(negedge clk);
    end
    req_valid = 1'b0;
    while (!cur.rdy) @(negedge clk);
  endtask

  initial begin
    cur = idle_e("R1");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);                                           // R1 reset idle state
    do_req("R3",  1'b0, 26'h0000100, 32'h0, 4'hF, 0);                    // R2 R3 first read
    do_req("R9",  1'b0, 26'h0000104, 32'h0, 4'hF, 0);                    // R9 next word, short wait
    do_req("R10", 1'b0, 26'h000010C, 32'h0, 4'hF, 0);                    // R10 skipped word
    do_req("R10", 1'b0, 26'h0000110, 32'h0, 4'hF, 0);                    // R10 page crossing
    do_req("R7",  1'b1, 26'h0000200, 32'h11223344, 4'b0110, 0);          // R7 R4 write after read
    do_req("R8",  1'b1, 26'h0000204, 32'hCAFEF00D, 4'hF, 0);             // R8 write after write
    do_req("R8",  1'b0, 26'h0000208, 32'h0, 4'hF, 0);                    // R8 read after write
    do_req("R6",  1'b0, 26'h1000002, 32'h0, 4'hF, 0);                    // R6 R11 region change
    do_req("R11", 1'b1, 26'h1000002, 32'hAABBCCDD, 4'b1100, 0);          // R11 upper halfword write
    do_req("R5",  1'b1, 26'h3000010, 32'hDEADBEEF, 4'hF, 1);             // R5 protected, held
    do_req("R13", 1'b0, 26'h3000010, 32'h0, 4'hF, 1);                    // R13 held read
    do_req("R12", 1'b0, 26'h2000003, 32'h0, 4'hF, 0);                    // R12 byte lane 3
    do_req("R9",  1'b0, 26'h2000004, 32'h0, 4'hF, 0);                    // R9 byte step
    do_req("R12", 1'b1, 26'h2000005, 32'h55667788, 4'b0010, 0);          // R12 R7 byte write
    do_req("R12", 1'b1, 26'h2000006, 32'h55667788, 4'b1011, 0);          // R12 disabled byte
    do_req("R2",  1'b0, 26'h0FFFFFC, 32'h0, 4'hF, 0);                    // R2 top address
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    for (cyc = 0; cyc < WATCHDOG; cyc++) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule